// File: doc/BRIEF.md
# Parallel port floppy pin multiplexer

This block sits between a parallel port engine, a floppy disk controller and the pads. A two-bit configuration field selects one of three modes. In normal mode, the parallel port owns its pins. In the two sharing modes, the floppy controller's drive interface is carried on the parallel pins. In the first sharing mode only the second drive is carried there. In the second sharing mode both drives are carried there. For every pad, the block decides whether the parallel port logic drives it, the floppy controller drives it, or nothing drives it.

While sharing is active, the parallel port cannot operate as a port. Register reads from software return a fixed picture of a port with no cable attached, and the data register returns the value most recently written to it. The DMA and interrupt sideband of the port is parked in safe states. The floppy path ignores the port's power bit. When the controller's drive select points at a drive that lives on the parallel pins, the dedicated floppy pads are released.

Every pad value, pad enable and read result is registered. A change on any input takes effect at the next rising clock edge.

Top module: `ppfloppy_mux`

## Requirements
- R1: The mode field decodes as follows: 00 and 11 are normal, 01 is sharing with drive 1 only, and 10 is sharing with drives 0 and 1. Every output is registered, and follows its inputs one rising edge later. During reset, all enables are 0, reg_rd_data is 0, the other data outputs are 0 and core_dack_n is 1.
- R2: In normal mode, pp_pin_out equals core_pin_out, and pp_pin_oe equals core_pin_oe when cfg_pwr_on is 1 and all zeros when it is 0. fd_pin_out equals fdc_pin_n, and every bit of fd_pin_oe is 1.
- R3: In either sharing mode, parallel pin i for i < 10 carries fdc_pin_n[i] with its enable at 1. Pins 10 and up have enable 0 and value 0. In the drive-1-only mode, the positions of drive 0 select (bit 7) and motor 0 (bit 8) on the parallel pins are driven 1 (inactive). The floppy bus order is: 0 write data, 1 density, 2 head select, 3 write gate, 4 direction, 5 step, 6 drive select 1, 7 drive select 0, 8 motor 0, 9 motor 1.
- R4: When the selected drive is not on the port, the dedicated pads are enabled as follows. In drive-1-only mode, bits 6 and 9 have enable 0 and the rest have enable 1. In two-drive mode, bits 6 to 9 have enable 0 and the rest have enable 1.
- R5: When the drive select (fdc_drv_sel) names a drive carried on the port, every bit of fd_pin_oe is 0. In drive-1-only mode this is drive 1. In two-drive mode this is drive 0 or drive 1.
- R6: Register address 0 is the data register. In normal mode, a read returns core_rd_data. While sharing, a read returns the last byte written to address 0 in any mode, and that byte is 0 after reset. A write and a read in the same cycle return the older byte.
- R7: While sharing, a read of address 2 (control) returns 8'h04: strobe (bit 0), autofeed (bit 1) and select-in (bit 3) are 0, and init (bit 2) is 1.
- R8: While sharing, a read of address 1 (status) returns 8'h48: busy_n (bit 7) is 0, ack_n (bit 6) is 1, paper-end (bit 5) is 0, select (bit 4) is 0, error_n (bit 3) is 1, and bits 2 to 0 are 0. Address 3 returns core_rd_data in every mode, and so does every address in normal mode.
- R9: While sharing, pp_dack_n is ignored and core_dack_n is 1. In normal mode, core_dack_n follows pp_dack_n.
- R10: While sharing, pp_irq_out is 0, and pp_irq_oe equals cfg_irq_low. In normal mode, pp_irq_out is core_irq and pp_irq_oe is cfg_pwr_on.
- R11: While sharing, pp_drq_out is 0, and pp_drq_oe is 1 only when cfg_ecp and cfg_dma_en are both 1. In normal mode, pp_drq_out is core_drq and pp_drq_oe is cfg_pwr_on.
- R12: pp_core_en is 0 while sharing, whatever the value of cfg_pwr_on. In normal mode, pp_core_en equals cfg_pwr_on. Sharing-mode pin routing does not depend on cfg_pwr_on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Sharing mode field |
| cfg_pwr_on | input | 1 | Parallel port power bit |
| cfg_ecp | input | 1 | Port is configured for ECP |
| cfg_dma_en | input | 1 | Port DMA enabled |
| cfg_irq_low | input | 1 | Drive idle interrupt low instead of floating it |
| fdc_drv_sel | input | 2 | Drive currently selected by the floppy controller |
| fdc_pin_n | input | 10 | Floppy output bus, active low |
| core_pin_out | input | PP_PINS | Parallel engine pin values |
| core_pin_oe | input | PP_PINS | Parallel engine pin enables |
| core_drq | input | 1 | Parallel engine DMA request |
| core_irq | input | 1 | Parallel engine interrupt |
| core_rd_data | input | 8 | Parallel engine register read data |
| reg_rd_addr | input | 2 | Register read address |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register write address |
| reg_wr_data | input | 8 | Register write data |
| pp_dack_n | input | 1 | DMA acknowledge pad |
| pp_pin_out | output | PP_PINS | Parallel pad values |
| pp_pin_oe | output | PP_PINS | Parallel pad enables |
| fd_pin_out | output | 10 | Dedicated floppy pad values |
| fd_pin_oe | output | 10 | Dedicated floppy pad enables |
| pp_drq_out | output | 1 | DMA request pad value |
| pp_drq_oe | output | 1 | DMA request pad enable |
| pp_irq_out | output | 1 | Interrupt pad value |
| pp_irq_oe | output | 1 | Interrupt pad enable |
| core_dack_n | output | 1 | DMA acknowledge passed to the engine |
| pp_core_en | output | 1 | Parallel engine is powered and usable |
| reg_rd_data | output | 8 | Register read result |

## Verification
Every result has a latency of one rising edge. This covers pad routing, pad enables, sideband states, the engine enable and the read data. The bench changes inputs on the falling edge and computes the expected outputs from those inputs. It compares them at the next falling edge, after exactly one rising edge has passed. The data-register shadow is the one piece of history. The bench model reads the old shadow before it applies a write from the same cycle, so a write and a read in one cycle expect the older byte.

// File: rtl/ppfd_pkg.sv
package ppfd_pkg;
    localparam int FD_W = 10;
    localparam int BI_WDATA = 0;
    localparam int BI_DS1   = 6;
    localparam int BI_DS0   = 7;
    localparam int BI_MTR0  = 8;
    localparam int BI_MTR1  = 9;

    localparam logic [1:0] RA_DATA = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_CTRL = 2'd2;

    localparam logic [7:0] NOCABLE_CTRL = 8'h04;
    localparam logic [7:0] NOCABLE_STAT = 8'h48;

    typedef enum logic [1:0] {
        SHARE_OFF = 2'b00,
        SHARE_D1  = 2'b01,
        SHARE_D01 = 2'b10
    } share_e;

    typedef struct packed {
        logic drq_out;
        logic drq_oe;
        logic irq_out;
        logic irq_oe;
        logic dack_n;
        logic core_en;
    } side_t;

    function automatic share_e decode_mode(input logic [1:0] m);
        case (m)
            2'b01:   return SHARE_D1;
            2'b10:   return SHARE_D01;
            default: return SHARE_OFF;
        endcase
    endfunction

    function automatic logic drive_on_port(input share_e s, input logic [1:0] sel);
        case (s)
            SHARE_D1:  return sel == 2'd1;
            SHARE_D01: return sel == 2'd0 || sel == 2'd1;
            default:   return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/ppfd_route.sv
module ppfd_route
    import ppfd_pkg::*;
#(
    parameter int PP_PINS = 17
) (
    input  logic               clk,
    input  logic               rst,
    input  share_e             mode,
    input  logic [1:0]         drv_sel,
    input  logic               pwr_on,
    input  logic [FD_W-1:0]    fdc_n,
    input  logic [PP_PINS-1:0] core_out,
    input  logic [PP_PINS-1:0] core_oe,
    output logic [PP_PINS-1:0] pp_out_q,
    output logic [PP_PINS-1:0] pp_oe_q,
    output logic [FD_W-1:0]    fd_out_q,
    output logic [FD_W-1:0]    fd_oe_q
);
    logic [PP_PINS-1:0] pp_o, pp_e;
    logic [FD_W-1:0]    fd_e;

    always_comb begin
        pp_o = core_out;
        pp_e = pwr_on ? core_oe : '0;
        fd_e = '1;
        if (mode != SHARE_OFF) begin
            pp_o = '0;
            pp_e = '0;
            for (int i = 0; i < FD_W; i++) begin
                pp_o[i] = fdc_n[i];
                pp_e[i] = 1'b1;
            end
            fd_e[BI_DS1]  = 1'b0;
            fd_e[BI_MTR1] = 1'b0;
            if (mode == SHARE_D1) begin
                pp_o[BI_DS0]  = 1'b1;
                pp_o[BI_MTR0] = 1'b1;
            end else begin
                fd_e[BI_DS0]  = 1'b0;
                fd_e[BI_MTR0] = 1'b0;
            end
            if (drive_on_port(mode, drv_sel)) fd_e = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pp_out_q <= '0;
            pp_oe_q  <= '0;
            fd_out_q <= '0;
            fd_oe_q  <= '0;
        end else begin
            pp_out_q <= pp_o;
            pp_oe_q  <= pp_e;
            fd_out_q <= fdc_n;
            fd_oe_q  <= fd_e;
        end
    end
endmodule

// File: rtl/ppfd_regview.sv
module ppfd_regview
    import ppfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sharing,
    input  logic [1:0] rd_addr,
    input  logic [7:0] core_rd,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_q
);
    logic [7:0] shadow_q;
    logic [7:0] rd_next;

    always_comb begin
        rd_next = core_rd;
        if (sharing) begin
            case (rd_addr)
                RA_DATA: rd_next = shadow_q;
                RA_STAT: rd_next = NOCABLE_STAT;
                RA_CTRL: rd_next = NOCABLE_CTRL;
                default: rd_next = core_rd;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            rd_q     <= '0;
        end else begin
            if (wr_en && wr_addr == RA_DATA) shadow_q <= wr_data;
            rd_q <= rd_next;
        end
    end
endmodule

// File: rtl/ppfd_sideband.sv
module ppfd_sideband
    import ppfd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sharing,
    input  logic  pwr_on,
    input  logic  ecp,
    input  logic  dma_en,
    input  logic  irq_low,
    input  logic  core_drq,
    input  logic  core_irq,
    input  logic  dack_n_pad,
    output side_t side_q
);
    side_t nxt;

    always_comb begin
        if (sharing) begin
            nxt.drq_out = 1'b0;
            nxt.drq_oe  = ecp & dma_en;
            nxt.irq_out = 1'b0;
            nxt.irq_oe  = irq_low;
            nxt.dack_n  = 1'b1;
            nxt.core_en = 1'b0;
        end else begin
            nxt.drq_out = core_drq;
            nxt.drq_oe  = pwr_on;
            nxt.irq_out = core_irq;
            nxt.irq_oe  = pwr_on;
            nxt.dack_n  = dack_n_pad;
            nxt.core_en = pwr_on;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            side_q        <= '0;
            side_q.dack_n <= 1'b1;
        end else begin
            side_q <= nxt;
        end
    end
endmodule

// File: rtl/ppfloppy_mux.sv
module ppfloppy_mux
    import ppfd_pkg::*;
#(
    parameter int PP_PINS = 17
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         cfg_mode,
    input  logic               cfg_pwr_on,
    input  logic               cfg_ecp,
    input  logic               cfg_dma_en,
    input  logic               cfg_irq_low,
    input  logic [1:0]         fdc_drv_sel,
    input  logic [FD_W-1:0]    fdc_pin_n,
    input  logic [PP_PINS-1:0] core_pin_out,
    input  logic [PP_PINS-1:0] core_pin_oe,
    input  logic               core_drq,
    input  logic               core_irq,
    input  logic [7:0]         core_rd_data,
    input  logic [1:0]         reg_rd_addr,
    input  logic               reg_wr_en,
    input  logic [1:0]         reg_wr_addr,
    input  logic [7:0]         reg_wr_data,
    input  logic               pp_dack_n,
    output logic [PP_PINS-1:0] pp_pin_out,
    output logic [PP_PINS-1:0] pp_pin_oe,
    output logic [FD_W-1:0]    fd_pin_out,
    output logic [FD_W-1:0]    fd_pin_oe,
    output logic               pp_drq_out,
    output logic               pp_drq_oe,
    output logic               pp_irq_out,
    output logic               pp_irq_oe,
    output logic               core_dack_n,
    output logic               pp_core_en,
    output logic [7:0]         reg_rd_data
);
    share_e mode;
    logic   sharing;
    side_t  side;

    assign mode    = decode_mode(cfg_mode);
    assign sharing = (mode != SHARE_OFF);

    ppfd_route #(.PP_PINS(PP_PINS)) u_route (
        .clk(clk), .rst(rst), .mode(mode), .drv_sel(fdc_drv_sel),
        .pwr_on(cfg_pwr_on), .fdc_n(fdc_pin_n),
        .core_out(core_pin_out), .core_oe(core_pin_oe),
        .pp_out_q(pp_pin_out), .pp_oe_q(pp_pin_oe),
        .fd_out_q(fd_pin_out), .fd_oe_q(fd_pin_oe)
    );

    ppfd_regview u_regs (
        .clk(clk), .rst(rst), .sharing(sharing), .rd_addr(reg_rd_addr),
        .core_rd(core_rd_data), .wr_en(reg_wr_en), .wr_addr(reg_wr_addr),
        .wr_data(reg_wr_data), .rd_q(reg_rd_data)
    );

    ppfd_sideband u_side (
        .clk(clk), .rst(rst), .sharing(sharing), .pwr_on(cfg_pwr_on),
        .ecp(cfg_ecp), .dma_en(cfg_dma_en), .irq_low(cfg_irq_low),
        .core_drq(core_drq), .core_irq(core_irq), .dack_n_pad(pp_dack_n),
        .side_q(side)
    );

    assign pp_drq_out  = side.drq_out;
    assign pp_drq_oe   = side.drq_oe;
    assign pp_irq_out  = side.irq_out;
    assign pp_irq_oe   = side.irq_oe;
    assign core_dack_n = side.dack_n;
    assign pp_core_en  = side.core_en;
endmodule

// File: rtl/ppfd_checker.sv
module ppfd_checker
    import ppfd_pkg::*;
#(
    parameter int PP_PINS = 17
) (
    input logic               clk,
    input logic               rst,
    input logic [1:0]         cfg_mode,
    input logic               cfg_ecp,
    input logic               cfg_dma_en,
    input logic [1:0]         fdc_drv_sel,
    input logic [1:0]         reg_rd_addr,
    input logic [PP_PINS-1:0] pp_pin_oe,
    input logic [FD_W-1:0]    fd_pin_oe,
    input logic               pp_drq_oe,
    input logic               core_dack_n,
    input logic               pp_core_en,
    input logic [7:0]         reg_rd_data
);
    logic shr;
    assign shr = (cfg_mode == 2'b01) || (cfg_mode == 2'b10);

    a_r5_port_drive_frees_pads: assert property (@(posedge clk) disable iff (rst)
        (shr && (fdc_drv_sel == 2'd1 || (cfg_mode == 2'b10 && fdc_drv_sel == 2'd0)))
        |=> (fd_pin_oe == '0));

    a_r3_upper_pins_released: assert property (@(posedge clk) disable iff (rst)
        shr |=> (pp_pin_oe[PP_PINS-1:FD_W] == '0) && (&pp_pin_oe[FD_W-1:0]));

    a_r8_status_nocable: assert property (@(posedge clk) disable iff (rst)
        (shr && reg_rd_addr == 2'd1) |=> (reg_rd_data == 8'h48));

    a_r7_control_nocable: assert property (@(posedge clk) disable iff (rst)
        (shr && reg_rd_addr == 2'd2) |=> (reg_rd_data == 8'h04));

    a_r9_dack_ignored: assert property (@(posedge clk) disable iff (rst)
        shr |=> core_dack_n);

    a_r11_drq_floats: assert property (@(posedge clk) disable iff (rst)
        (shr && !(cfg_ecp && cfg_dma_en)) |=> !pp_drq_oe);

    a_r12_engine_off: assert property (@(posedge clk) disable iff (rst)
        shr |=> !pp_core_en);
endmodule

bind ppfloppy_mux ppfd_checker #(.PP_PINS(PP_PINS)) i_ppfd_checker (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_ecp(cfg_ecp),
    .cfg_dma_en(cfg_dma_en), .fdc_drv_sel(fdc_drv_sel), .reg_rd_addr(reg_rd_addr),
    .pp_pin_oe(pp_pin_oe), .fd_pin_oe(fd_pin_oe), .pp_drq_oe(pp_drq_oe),
    .core_dack_n(core_dack_n), .pp_core_en(pp_core_en), .reg_rd_data(reg_rd_data)
);

// File: tb/test_ppfloppy_mux.sv
`timescale 1ns/1ps
module test_ppfloppy_mux;
    localparam int NP = 17;
    localparam int NF = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [1:0] cfg_mode = '0, fdc_drv_sel = '0, reg_rd_addr = '0, reg_wr_addr = '0;
    logic cfg_pwr_on = 0, cfg_ecp = 0, cfg_dma_en = 0, cfg_irq_low = 0;
    logic core_drq = 0, core_irq = 0, reg_wr_en = 0, pp_dack_n = 1;
    logic [NF-1:0] fdc_pin_n = '0;
    logic [NP-1:0] core_pin_out = '0, core_pin_oe = '0;
    logic [7:0] core_rd_data = '0, reg_wr_data = '0;

    logic [NP-1:0] pp_pin_out, pp_pin_oe;
    logic [NF-1:0] fd_pin_out, fd_pin_oe;
    logic pp_drq_out, pp_drq_oe, pp_irq_out, pp_irq_oe, core_dack_n, pp_core_en;
    logic [7:0] reg_rd_data;

    ppfloppy_mux #(.PP_PINS(NP)) i_ppfloppy_mux (.*);

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] m_shadow = 8'h00;

    logic [NP-1:0] e_ppo, e_ppe;
    logic [NF-1:0] e_fdo, e_fde;
    logic e_drqo, e_drqe, e_irqo, e_irqe, e_dack, e_en;
    logic [7:0] e_rd;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // model of the requirements, evaluated on the inputs applied this cycle
    task automatic compute_expected();
        bit sh, d1;
        sh = (cfg_mode == 2'b01) || (cfg_mode == 2'b10);
        d1 = (cfg_mode == 2'b01);
        if (!sh) begin
            e_ppo = core_pin_out;
            e_ppe = cfg_pwr_on ? core_pin_oe : '0;
            e_fde = '1;
        end else begin
            e_ppo = '0; e_ppe = '0;
            for (int i = 0; i < NF; i++) begin e_ppo[i] = fdc_pin_n[i]; e_ppe[i] = 1'b1; end
            if (d1) begin e_ppo[7] = 1'b1; e_ppo[8] = 1'b1; end
            e_fde = d1 ? 10'b01_1011_1111 : 10'b00_0011_1111;
            if (fdc_drv_sel == 2'd1 || (!d1 && fdc_drv_sel == 2'd0)) e_fde = '0;
        end
        e_fdo  = fdc_pin_n;
        e_drqo = sh ? 1'b0 : core_drq;
        e_drqe = sh ? (cfg_ecp & cfg_dma_en) : cfg_pwr_on;
        e_irqo = sh ? 1'b0 : core_irq;
        e_irqe = sh ? cfg_irq_low : cfg_pwr_on;
        e_dack = sh ? 1'b1 : pp_dack_n;
        e_en   = sh ? 1'b0 : cfg_pwr_on;
        if (!sh || reg_rd_addr == 2'd3) e_rd = core_rd_data;
        else if (reg_rd_addr == 2'd0)   e_rd = m_shadow;
        else if (reg_rd_addr == 2'd1)   e_rd = 8'h48;
        else                            e_rd = 8'h04;
        if (reg_wr_en && reg_wr_addr == 2'd0) m_shadow = reg_wr_data;
    endtask

    task automatic check_all();
        chk("R2/R3 pp_pin_out", 32'(pp_pin_out), 32'(e_ppo));
        chk("R2/R3/R12 pp_pin_oe", 32'(pp_pin_oe), 32'(e_ppe));
        chk("R2 fd_pin_out", 32'(fd_pin_out), 32'(e_fdo));
        chk("R4/R5 fd_pin_oe", 32'(fd_pin_oe), 32'(e_fde));
        chk("R11 drq", {30'd0, pp_drq_out, pp_drq_oe}, {30'd0, e_drqo, e_drqe});
        chk("R10 irq", {30'd0, pp_irq_out, pp_irq_oe}, {30'd0, e_irqo, e_irqe});
        chk("R9 core_dack_n", 32'(core_dack_n), 32'(e_dack));
        chk("R12 pp_core_en", 32'(pp_core_en), 32'(e_en));
        chk("R6/R7/R8 reg_rd_data", 32'(reg_rd_data), 32'(e_rd));
    endtask

    task automatic randomize_inputs(input logic [1:0] mode);
        cfg_mode     = mode;
        cfg_pwr_on   = 1'($urandom);
        cfg_ecp      = 1'($urandom);
        cfg_dma_en   = 1'($urandom);
        cfg_irq_low  = 1'($urandom);
        fdc_drv_sel  = 2'($urandom);
        fdc_pin_n    = NF'($urandom);
        core_pin_out = NP'($urandom);
        core_pin_oe  = NP'($urandom);
        core_drq     = 1'($urandom);
        core_irq     = 1'($urandom);
        core_rd_data = 8'($urandom);
        reg_rd_addr  = 2'($urandom);
        reg_wr_en    = 1'($urandom);
        reg_wr_addr  = 2'($urandom);
        reg_wr_data  = 8'($urandom);
        pp_dack_n    = 1'($urandom);
    endtask

    task automatic step();
        compute_expected();
        @(negedge clk);
        check_all();
    endtask

    initial begin
        void'($urandom(32'd7319));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 reset pp_pin_oe", 32'(pp_pin_oe), 0);
        chk("R1 reset fd_pin_oe", 32'(fd_pin_oe), 0);
        chk("R1 reset rd_data", 32'(reg_rd_data), 0);
        chk("R1 reset dack", 32'(core_dack_n), 1);
        chk("R1 reset core_en", 32'(pp_core_en), 0);
        rst = 1'b0;

        // R6: write in normal mode, then read back in sharing mode
        randomize_inputs(2'b00);
        reg_wr_en = 1; reg_wr_addr = 0; reg_wr_data = 8'hA5;
        step();
        randomize_inputs(2'b10);
        reg_wr_en = 0; reg_rd_addr = 0;
        step();
        chk("R6 shadow read", 32'(reg_rd_data), 32'h00A5);
        // R6: same-cycle write and read returns the older byte
        randomize_inputs(2'b01);
        reg_wr_en = 1; reg_wr_addr = 0; reg_wr_data = 8'h3C; reg_rd_addr = 0;
        step();
        chk("R6 old byte", 32'(reg_rd_data), 32'h00A5);
        // R1: 11 behaves as normal
        randomize_inputs(2'b11);
        cfg_pwr_on = 1;
        step();
        chk("R1 mode 11 core_en", 32'(pp_core_en), 1);
        // R12: sharing with power off still routes floppy
        randomize_inputs(2'b01);
        cfg_pwr_on = 0; fdc_drv_sel = 2'd0;
        step();
        chk("R12 sharing pads on", 32'(pp_pin_oe[NF-1:0]), 32'h3FF);
        // R5 corners for each selected drive
        for (int s = 0; s < 4; s++) begin
            randomize_inputs(2'b10);
            fdc_drv_sel = 2'(s);
            step();
        end
        // R11: ECP with DMA enabled drives request low
        randomize_inputs(2'b10);
        cfg_ecp = 1; cfg_dma_en = 1;
        step();
        chk("R11 ecp drq", {30'd0, pp_drq_out, pp_drq_oe}, 32'd1);

        for (int n = 0; n < 3000; n++) begin
            randomize_inputs(2'($urandom));
            step();
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule